// File: doc/BRIEF.md
# PCI Target Posted-Write Controller

This block is the target side of a PCI interface for write bursts aimed at main memory. When a master starts a transaction, the controller drives a short fixed series of commands to an external data-path unit. The first command keeps the captured address. The second copies that address into the write-buffer address register. The third puts the address on the host bus. At the same time as the third command, the controller requests a cache snoop that invalidates any matching line. The controller claims the transaction only when the memory-select input confirms that the address belongs to main memory.

Write data is posted into two buffers that are used in turn, each four Dwords deep. A buffer passes to the drain side once it is full or once the burst ends. A full buffer causes a disconnect through STOP. When the drain side has not yet released the buffer that is due next, the controller holds TRDY low. The drain side reads the posted Dwords through a registered read port, then releases the buffer with an acknowledge pulse.

All bus signals on the ports are active-high logical levels. Conversion to the active-low pins happens outside this block.

Top module: `pci_pw_target`

## Requirements
- R1: During reset and after it, devsel_o, trdy_o, stop_o, snoop_o, snoop_inv_o, l2_snoop_o and drain_valid_o are 0, and dp_cmd_o and host_cmd_o are 0 (idle).
- R2: The clock edge that samples frame_i high while idle makes dp_cmd_o equal 1 (keep address) for one cycle. If memsel_i is high at the next edge, dp_cmd_o equals 2 (load write-buffer address) for one cycle. In the cycle after that, host_cmd_o equals 1 (drive write address) for one cycle and dp_cmd_o returns to 0.
- R3: snoop_o, snoop_inv_o and l2_snoop_o are high together for exactly one cycle, which is the cycle in which host_cmd_o equals 1.
- R4: If memsel_i is low at the edge that ends the keep-address cycle, devsel_o and trdy_o stay 0 and no further commands are issued until frame_i is low. No data from that transaction is stored.
- R5: devsel_o is high from the load-address cycle until the transaction is released.
- R6: Starting in the cycle after the host-drive command, trdy_o is high while the current buffer is free. Each edge with irdy_i and trdy_o both high stores ad_i as the next Dword, in order.
- R7: After the fourth Dword enters a buffer while frame_i is still high, the next cycle shows stop_o high, trdy_o low and devsel_o high.
- R8: In the stop state, the edge that samples frame_i low is followed by one more cycle with stop_o and devsel_o high. Both go low at the following edge.
- R9: If frame_i is low on the final data transfer, devsel_o, trdy_o and stop_o go low at that same edge, with no STOP even when that Dword fills the buffer. The partially filled buffer is handed over with its count. A burst that ends with no Dword transferred hands over nothing.
- R10: Buffers are filled in turn and handed over in fill order. drain_sel_o names the buffer (0 or 1), drain_cnt_o gives its Dword count (1 to 4), and drain_addr_o gives the transaction's start address.
- R11: When the buffer due next is still held by the drain side, trdy_o stays low. It rises at the edge where drain_ack_i releases that buffer.
- R12: drain_data_o shows the Dword at index drain_idx_i of the buffer being handed over, one clock after the index is applied. drain_ack_i releases that buffer. drain_ack_i while drain_valid_o is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Master frame, high while the transaction is active |
| irdy_i | input | 1 | Master ready |
| memsel_i | input | 1 | Address decodes to main memory |
| ad_i | input | 32 | Address/data bus |
| devsel_o | output | 1 | Target claims the transaction |
| trdy_o | output | 1 | Target ready for data |
| stop_o | output | 1 | Target disconnect request |
| dp_cmd_o | output | 2 | Data-path command: 0 idle, 1 keep address, 2 load write-buffer address |
| host_cmd_o | output | 2 | Host-side command: 0 idle, 1 drive write address |
| snoop_o | output | 1 | First-level snoop strobe |
| snoop_inv_o | output | 1 | Invalidate qualifier for the snoop |
| l2_snoop_o | output | 1 | Internal second-level snoop request |
| drain_valid_o | output | 1 | A buffer is handed over to the drain side |
| drain_sel_o | output | 1 | Index of the buffer being handed over |
| drain_cnt_o | output | 3 | Valid Dwords in the handed-over buffer |
| drain_addr_o | output | 32 | Start address of the handed-over buffer |
| drain_idx_i | input | 2 | Dword index for the drain read |
| drain_data_o | output | 32 | Registered drain read data |
| drain_ack_i | input | 1 | Drain side releases the handed-over buffer |

## Verification
A wrong state in the bus sequencer appears within one clock as a command code on dp_cmd_o or host_cmd_o that is missing, repeated or out of order, or as a DEVSEL that is claimed or released a cycle early. Errors in the fill count show up on the fourth accepted Dword: STOP arrives early or late, or drain_cnt_o carries the wrong value. A wrong ownership flag or a wrong alternation pointer shows up only on the next transaction. It then appears as TRDY stalling while a buffer is free or not stalling while none is, or as drain_sel_o and drain_addr_o handing buffers over out of order. The stimulus therefore chains back-to-back bursts, holds the drain side back, and releases it in the middle of a stall.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_LOADWB,
    ST_HOSTA,
    ST_XFER,
    ST_STOPW,
    ST_TURN,
    ST_IGN
  } pwt_state_e;

  localparam int CMD_W = 2;

  // Data-path command codes
  localparam logic [CMD_W-1:0] DP_NOP    = 2'd0;
  localparam logic [CMD_W-1:0] DP_HOLD   = 2'd1;
  localparam logic [CMD_W-1:0] DP_LOADWB = 2'd2;

  // Host-side command codes
  localparam logic [CMD_W-1:0] HC_NOP    = 2'd0;
  localparam logic [CMD_W-1:0] HC_DRVADR = 2'd1;

endpackage

// File: rtl/pwt_buf_mem.sv
// Posted-write storage: both buffers in one array, synchronous write and
// registered read so that the array maps onto block RAM.
module pwt_buf_mem #(
  parameter int W  = 32,
  parameter int AB = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AB-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AB-1:0] ra,
  output logic [W-1:0]  rd
);

  localparam int ENTRIES = 2 ** AB;

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[wa] <= wd;
    end
    rd <= mem[ra];
  end

endmodule

// File: rtl/pwt_buf_ctl.sv
// Ping-pong ownership, fill counting and hand-over to the drain side.
module pwt_buf_ctl #(
  parameter  int W     = 32,
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic          fin_i,
  input  logic          addr_cap_i,
  input  logic [W-1:0]  addr_i,
  input  logic          drain_ack_i,
  output logic          last_slot_o,
  output logic          free_n_o,
  output logic [IW:0]   wr_addr_o,
  output logic          drain_valid_o,
  output logic          drain_sel_o,
  output logic [CW-1:0] drain_cnt_o,
  output logic [W-1:0]  drain_addr_o
);

  localparam int NBUF = 2;

  logic          wsel_q, head_q, wsel_n;
  logic [CW-1:0] cnt_q, cnt_new;
  logic [W-1:0]  taddr_q;
  logic [NBUF-1:0] busy_q, busy_n;
  logic [CW-1:0] bcnt_q  [NBUF];
  logic [W-1:0]  baddr_q [NBUF];
  logic          hand, ack;

  assign cnt_new = cnt_q + CW'(wr_i);
  // Hand over on the fill of the last slot, or at burst end if anything is held
  assign hand    = (wr_i && cnt_q == CW'(DEPTH - 1)) || (fin_i && cnt_new != '0);
  assign ack     = drain_ack_i && busy_q[head_q];
  assign wsel_n  = wsel_q ^ hand;

  always_comb begin
    busy_n = busy_q;
    if (ack)  busy_n[head_q] = 1'b0;
    if (hand) busy_n[wsel_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel_q  <= 1'b0;
      head_q  <= 1'b0;
      cnt_q   <= '0;
      busy_q  <= '0;
      taddr_q <= '0;
    end else begin
      wsel_q <= wsel_n;
      head_q <= head_q ^ ack;
      busy_q <= busy_n;
      cnt_q  <= hand ? '0 : cnt_new;
      if (addr_cap_i) taddr_q <= addr_i;
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst) begin
        bcnt_q[g]  <= '0;
        baddr_q[g] <= '0;
      end else if (hand && wsel_q == 1'(g)) begin
        bcnt_q[g]  <= cnt_new;
        baddr_q[g] <= taddr_q;
      end
    end
  end

  assign last_slot_o   = (cnt_q == CW'(DEPTH - 1));
  assign free_n_o      = !busy_n[wsel_n];
  assign wr_addr_o     = {wsel_q, cnt_q[IW-1:0]};
  assign drain_valid_o = busy_q[head_q];
  assign drain_sel_o   = head_q;
  assign drain_cnt_o   = bcnt_q[head_q];
  assign drain_addr_o  = baddr_q[head_q];

endmodule

// File: rtl/pwt_bus_fsm.sv
// Target bus sequencer: command series, snoop pulse and DEVSEL/TRDY/STOP.
module pwt_bus_fsm
  import pwt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_i,
  input  logic             irdy_i,
  input  logic             memsel_i,
  input  logic             last_slot_i,
  input  logic             free_n_i,
  output logic             devsel_o,
  output logic             trdy_o,
  output logic             stop_o,
  output logic [CMD_W-1:0] dp_cmd_o,
  output logic [CMD_W-1:0] host_cmd_o,
  output logic             snoop_o,
  output logic             snoop_inv_o,
  output logic             l2_snoop_o,
  output logic             wr_o,
  output logic             fin_o,
  output logic             addr_cap_o
);

  pwt_state_e st_q, st_n;

  assign wr_o       = (st_q == ST_XFER) && irdy_i && trdy_o;
  assign fin_o      = (st_q == ST_XFER) && !frame_i && (!irdy_i || trdy_o);
  assign addr_cap_o = (st_q == ST_IDLE) && frame_i;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:   if (frame_i) st_n = ST_HOLD;
      ST_HOLD:   st_n = memsel_i ? ST_LOADWB : ST_IGN;
      ST_LOADWB: st_n = ST_HOSTA;
      ST_HOSTA:  st_n = ST_XFER;
      ST_XFER: begin
        if (fin_o)                     st_n = ST_IDLE;
        else if (wr_o && last_slot_i)  st_n = ST_STOPW;
      end
      ST_STOPW:  if (!frame_i) st_n = ST_TURN;
      ST_TURN:   st_n = ST_IDLE;
      ST_IGN:    if (!frame_i) st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      devsel_o    <= 1'b0;
      trdy_o      <= 1'b0;
      stop_o      <= 1'b0;
      dp_cmd_o    <= DP_NOP;
      host_cmd_o  <= HC_NOP;
      snoop_o     <= 1'b0;
      snoop_inv_o <= 1'b0;
      l2_snoop_o  <= 1'b0;
    end else begin
      st_q        <= st_n;
      devsel_o    <= st_n inside {ST_LOADWB, ST_HOSTA, ST_XFER, ST_STOPW, ST_TURN};
      trdy_o      <= (st_n == ST_XFER) && free_n_i;
      stop_o      <= st_n inside {ST_STOPW, ST_TURN};
      dp_cmd_o    <= (st_n == ST_HOLD)   ? DP_HOLD :
                     (st_n == ST_LOADWB) ? DP_LOADWB : DP_NOP;
      host_cmd_o  <= (st_n == ST_HOSTA) ? HC_DRVADR : HC_NOP;
      snoop_o     <= (st_n == ST_HOSTA);
      snoop_inv_o <= (st_n == ST_HOSTA);
      l2_snoop_o  <= (st_n == ST_HOSTA);
    end
  end

endmodule

// File: rtl/pci_pw_target.sv
module pci_pw_target
  import pwt_pkg::*;
#(
  parameter  int W     = 32,
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_i,
  input  logic             irdy_i,
  input  logic             memsel_i,
  input  logic [W-1:0]     ad_i,
  output logic             devsel_o,
  output logic             trdy_o,
  output logic             stop_o,
  output logic [CMD_W-1:0] dp_cmd_o,
  output logic [CMD_W-1:0] host_cmd_o,
  output logic             snoop_o,
  output logic             snoop_inv_o,
  output logic             l2_snoop_o,
  output logic             drain_valid_o,
  output logic             drain_sel_o,
  output logic [CW-1:0]    drain_cnt_o,
  output logic [W-1:0]     drain_addr_o,
  input  logic [IW-1:0]    drain_idx_i,
  output logic [W-1:0]     drain_data_o,
  input  logic             drain_ack_i
);

  logic          wr, fin, addr_cap, last_slot, free_n;
  logic [IW:0]   wr_addr;

  pwt_bus_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .frame_i     (frame_i),
    .irdy_i      (irdy_i),
    .memsel_i    (memsel_i),
    .last_slot_i (last_slot),
    .free_n_i    (free_n),
    .devsel_o    (devsel_o),
    .trdy_o      (trdy_o),
    .stop_o      (stop_o),
    .dp_cmd_o    (dp_cmd_o),
    .host_cmd_o  (host_cmd_o),
    .snoop_o     (snoop_o),
    .snoop_inv_o (snoop_inv_o),
    .l2_snoop_o  (l2_snoop_o),
    .wr_o        (wr),
    .fin_o       (fin),
    .addr_cap_o  (addr_cap)
  );

  pwt_buf_ctl #(.W(W), .DEPTH(DEPTH)) u_ctl (
    .clk           (clk),
    .rst           (rst),
    .wr_i          (wr),
    .fin_i         (fin),
    .addr_cap_i    (addr_cap),
    .addr_i        (ad_i),
    .drain_ack_i   (drain_ack_i),
    .last_slot_o   (last_slot),
    .free_n_o      (free_n),
    .wr_addr_o     (wr_addr),
    .drain_valid_o (drain_valid_o),
    .drain_sel_o   (drain_sel_o),
    .drain_cnt_o   (drain_cnt_o),
    .drain_addr_o  (drain_addr_o)
  );

  pwt_buf_mem #(.W(W), .AB(IW + 1)) u_mem (
    .clk (clk),
    .we  (wr),
    .wa  (wr_addr),
    .wd  (ad_i),
    .ra  ({drain_sel_o, drain_idx_i}),
    .rd  (drain_data_o)
  );

endmodule

// File: rtl/pwt_chk.sv
module pwt_chk
  import pwt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             frame_i,
  input logic             memsel_i,
  input logic             devsel_o,
  input logic             trdy_o,
  input logic             stop_o,
  input logic [CMD_W-1:0] dp_cmd_o,
  input logic [CMD_W-1:0] host_cmd_o,
  input logic             snoop_o,
  input logic             snoop_inv_o,
  input logic             l2_snoop_o,
  input logic             drain_valid_o,
  input logic             drain_ack_i
);

  p_load_after_hold_r2: assert property (@(posedge clk) disable iff (rst)
    dp_cmd_o == DP_LOADWB |-> $past(dp_cmd_o) == DP_HOLD);

  p_drive_after_load_r2: assert property (@(posedge clk) disable iff (rst)
    host_cmd_o == HC_DRVADR |-> $past(dp_cmd_o) == DP_LOADWB);

  p_snoop_trio_r3: assert property (@(posedge clk) disable iff (rst)
    snoop_o |-> snoop_inv_o && l2_snoop_o && host_cmd_o == HC_DRVADR && devsel_o);

  p_no_claim_r4: assert property (@(posedge clk) disable iff (rst)
    (dp_cmd_o == DP_HOLD && !memsel_i) |=> (!devsel_o && dp_cmd_o == DP_NOP));

  p_trdy_claimed_r6: assert property (@(posedge clk) disable iff (rst)
    trdy_o |-> devsel_o && !stop_o);

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_o) |-> !devsel_o && !$past(frame_i));

  p_drain_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (drain_valid_o && !drain_ack_i) |=> drain_valid_o);

endmodule

bind pci_pw_target pwt_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_i       (frame_i),
  .memsel_i      (memsel_i),
  .devsel_o      (devsel_o),
  .trdy_o        (trdy_o),
  .stop_o        (stop_o),
  .dp_cmd_o      (dp_cmd_o),
  .host_cmd_o    (host_cmd_o),
  .snoop_o       (snoop_o),
  .snoop_inv_o   (snoop_inv_o),
  .l2_snoop_o    (l2_snoop_o),
  .drain_valid_o (drain_valid_o),
  .drain_ack_i   (drain_ack_i)
);

// File: tb/pci_pw_target_tb.sv
`timescale 1ns/1ps
module pci_pw_target_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame = 1'b0, irdy = 1'b0, memsel = 1'b0, ack = 1'b0;
  logic [31:0] ad = '0;
  logic [1:0]  idx = '0;
  logic        devsel, trdy, stop, snoop, inv, l2, dvalid, dsel;
  logic [1:0]  dp_cmd, host_cmd;
  logic [2:0]  dcnt;
  logic [31:0] daddr, ddata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic exp_buf = 1'b0;

  always #10 clk = ~clk;

  pci_pw_target u_dut (
    .clk(clk), .rst(rst), .frame_i(frame), .irdy_i(irdy), .memsel_i(memsel),
    .ad_i(ad), .devsel_o(devsel), .trdy_o(trdy), .stop_o(stop),
    .dp_cmd_o(dp_cmd), .host_cmd_o(host_cmd), .snoop_o(snoop),
    .snoop_inv_o(inv), .l2_snoop_o(l2), .drain_valid_o(dvalid),
    .drain_sel_o(dsel), .drain_cnt_o(dcnt), .drain_addr_o(daddr),
    .drain_idx_i(idx), .drain_data_o(ddata), .drain_ack_i(ack)
  );

  // {memsel, nwords[2:0], early_end, addr[31:0]}
  localparam logic [36:0] VEC [7] = '{
    {1'b1, 3'd4, 1'b0, 32'h1000_0000},
    {1'b1, 3'd2, 1'b1, 32'h2000_0040},
    {1'b0, 3'd3, 1'b0, 32'h3000_0000},
    {1'b1, 3'd1, 1'b1, 32'h4000_0100},
    {1'b1, 3'd4, 1'b1, 32'h5000_0000},
    {1'b1, 3'd0, 1'b1, 32'h6000_0000},
    {1'b1, 3'd3, 1'b1, 32'h7000_0200}
  };

  function automatic logic [31:0] dword(input logic [31:0] a, input int i);
    return a ^ (32'h0F0F_0000 | 32'(i + 1));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic addr_phase(input logic [31:0] a, input logic ms);
    frame = 1'b1; ad = a; memsel = ms; irdy = 1'b0;
    cyc();
    chk("R2 keep-address command", dp_cmd, 1);
    chk("R4 no claim during decode", devsel, 0);
    cyc();
    if (!ms) begin
      chk("R4 no load command", dp_cmd, 0);
      chk("R4 no claim", devsel, 0);
      return;
    end
    chk("R2 load command", dp_cmd, 2);
    chk("R5 claimed at load", devsel, 1);
    cyc();
    chk("R2 host drive command", host_cmd, 1);
    chk("R2 data-path idle", dp_cmd, 0);
    chk("R3 snoop with invalidate", {29'd0, snoop, inv, l2}, 3'b111);
    cyc();
    chk("R3 snoop one cycle", snoop, 0);
    chk("R2 host idle", host_cmd, 0);
  endtask

  task automatic data_phase(input logic [31:0] a, input int nw, input logic early);
    for (int i = 0; i < nw; i++) begin
      chk("R6 trdy ready", trdy, 1);
      irdy = 1'b1; ad = dword(a, i);
      frame = !(early && i == nw - 1);
      cyc();
    end
    if (nw == 0) begin
      frame = 1'b0; irdy = 1'b0;
      cyc();
    end
    irdy = 1'b0;
    if (early) begin
      chk("R9 devsel released", devsel, 0);
      chk("R9 trdy released", trdy, 0);
      chk("R9 no stop", stop, 0);
    end else begin
      chk("R7 stop on full", stop, 1);
      chk("R7 trdy off", trdy, 0);
      chk("R7 devsel held", devsel, 1);
      frame = 1'b0;
      cyc();
      chk("R8 stop held one cycle", stop, 1);
      chk("R8 devsel held one cycle", devsel, 1);
      cyc();
      chk("R8 stop released", stop, 0);
      chk("R8 devsel released", devsel, 0);
    end
  endtask

  task automatic drain_check(input logic [31:0] a, input int nw);
    if (nw == 0) begin
      chk("R9 empty burst hands nothing", dvalid, 0);
      return;
    end
    chk("R10 drain valid", dvalid, 1);
    chk("R10 buffer order", dsel, exp_buf);
    chk("R10 dword count", dcnt, nw);
    chk("R10 start address", daddr, a);
    for (int j = 0; j < nw; j++) begin
      idx = 2'(j);
      cyc();
      chk("R12 drain read data", ddata, dword(a, j));
    end
    ack = 1'b1;
    cyc();
    ack = 1'b0;
    exp_buf = ~exp_buf;
  endtask

  initial begin : wd
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 devsel in reset", devsel, 0);
    chk("R1 drain valid in reset", dvalid, 0);
    rst = 1'b0;
    cyc();
    chk("R1 bus outputs idle", {devsel, trdy, stop, snoop, inv, l2}, 0);
    chk("R1 commands idle", {dp_cmd, host_cmd}, 0);
    chk("R1 no drain", dvalid, 0);

    for (int k = 0; k < 7; k++) begin
      logic [31:0] a;
      logic ms, early;
      int nw;
      a = VEC[k][31:0]; early = VEC[k][32]; nw = int'(VEC[k][35:33]); ms = VEC[k][36];
      addr_phase(a, ms);
      if (ms) begin
        data_phase(a, nw, early);
        drain_check(a, nw);
      end else begin
        irdy = 1'b1; ad = dword(a, 0);
        cyc();
        chk("R4 ignored: no devsel", devsel, 0);
        chk("R4 ignored: no trdy", trdy, 0);
        frame = 1'b0; irdy = 1'b0;
        cyc();
        chk("R4 ignored: nothing stored", dvalid, 0);
      end
      cyc();
    end

    // Stall: both buffers held by the drain side
    addr_phase(32'hA000_0000, 1'b1);
    data_phase(32'hA000_0000, 4, 1'b0);
    addr_phase(32'hB000_0000, 1'b1);
    data_phase(32'hB000_0000, 4, 1'b0);
    addr_phase(32'hC000_0000, 1'b1);
    chk("R11 stall on both full", trdy, 0);
    irdy = 1'b1; ad = dword(32'hC000_0000, 0);
    for (int s = 0; s < 3; s++) begin
      cyc();
      chk("R11 trdy held low", trdy, 0);
      chk("R11 still claimed", devsel, 1);
    end
    chk("R10 oldest first", daddr, 32'hA000_0000);
    chk("R10 oldest buffer", dsel, exp_buf);
    ack = 1'b1;
    cyc();
    ack = 1'b0;
    exp_buf = ~exp_buf;
    chk("R11 trdy resumes on release", trdy, 1);
    frame = 1'b0;
    cyc();
    irdy = 1'b0;
    chk("R9 released after final dword", devsel, 0);
    drain_check(32'hB000_0000, 4);
    drain_check(32'hC000_0000, 1);
    chk("R10 all drained", dvalid, 0);

    // Acknowledge without a handed-over buffer is ignored
    ack = 1'b1;
    cyc();
    ack = 1'b0;
    chk("R12 stray ack keeps empty", dvalid, 0);
    addr_phase(32'hD000_0010, 1'b1);
    data_phase(32'hD000_0010, 2, 1'b1);
    drain_check(32'hD000_0010, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule